// File: doc/BRIEF.md
# USB Host Port Status and Control Register

This block holds the 32-bit status and control word for one USB 2.0 host root-hub port. Software reads it over a plain one-cycle write strobe and a combinational read bus. Hardware event inputs update it: device attach level, over-current level, a J-to-K detect strobe, the high-speed result of bus reset, a fault strobe, port power and a configured flag. Each field follows its own update rules. Change flags are sticky and write-one-to-clear. The enable bit can only be set by hardware. Suspend and resume, and bus reset, each run as a short sequence.

Ending a resume or a bus reset is modelled as a fixed, parameterised number of clock cycles after software writes the bit to zero. This stands in for the millisecond-scale line timing. Control levels for resume, reset, suspend and the test mode leave the block as outputs. A one-cycle port-change pulse marks a resume that the hardware detected. When port power is low, the powered fields are held at zero.

Top module: `port_ctl_reg`

## Requirements
- R1: After reset the register reads 0x00002000. Writes to reserved bits 9, 12, 14, 15 and 31:22, and to the read-only bits 0, 4 and 11:10, leave the read value unchanged.
- R2: Bit 0 shows the attach level one clock after the input. Bit 1 sets on every change of bit 0, even when it is already set. Writing a one to bit 1 clears it. A hardware set in the same cycle as that clear wins.
- R3: Bit 2 (enabled) ignores software writes of one. It clears on a software write of zero or on a device detach, and neither of these sets bit 3.
- R4: A fault strobe while bit 2 is set clears bit 2 and sets bit 3. A fault while the port is disabled leaves bit 3 at zero. Writing a one to bit 3 clears it.
- R5: Bit 4 follows the over-current input one clock later. Bit 5 sets on every change of bit 4 and is cleared by writing a one.
- R6: Bit 6 (resume) sets either on a software write of one or on a J-to-K strobe while bit 7 is set. Only the hardware-detected set produces a one-cycle port_chg_o pulse, in the same cycle that bit 6 first reads one.
- R7: A software write of zero to bit 6 while it is one keeps bit 6 at one for RESUME_CYC clocks after the write. Bit 6 and bit 7 then both read zero.
- R8: Bit 7 (suspend) sets on a write of one and ignores writes of zero. It clears in the cycle that a bus reset starts.
- R9: A write of one to bit 8 while it is zero starts bus reset: bit 8 and rst_o read one and bit 2 clears. A later write of zero keeps bit 8 at one for RESET_CYC clocks. Then bit 8 clears, and bit 2 becomes one only if hs_dev_i is high and a device is attached.
- R10: Bits 11:10 show line_i (bit 11 is D+, bit 10 is D-) while the port is disabled and a device is attached. In every other state they read zero.
- R11: Bit 13 (owner) is forced to one in every cycle where cfg_i is low. It goes to zero on the first cycle after cfg_i rises. Otherwise it takes software writes.
- R12: Bits 19:16 store the test mode written by software and drive test_mode_o. The codes are 0 none, 1 J, 2 K, 3 SE0 NAK, 4 packet, 5 force enable. Bits 20 (wake on attach) and 21 (wake on detach) store written values.
- R13: While pwr_i is low, bits 0, 1, 2, 3, 6, 7, 8, 20 and 21 read zero, writes to them are ignored, and any resume or reset sequence in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read value |
| attach_i | input | 1 | Device attached level |
| ovc_i | input | 1 | Over-current level |
| jk_det_i | input | 1 | J-to-K transition seen on the line |
| hs_dev_i | input | 1 | High-speed device detected during bus reset |
| fault_i | input | 1 | Port fault strobe |
| pwr_i | input | 1 | Port power |
| cfg_i | input | 1 | Configured flag |
| line_i | input | 2 | Line levels, [1] D+, [0] D- |
| port_chg_o | output | 1 | Port-change pulse for a hardware-detected resume |
| resume_o | output | 1 | Drive resume signalling |
| rst_o | output | 1 | Drive bus reset |
| susp_o | output | 1 | Port suspended |
| test_mode_o | output | 4 | Selected test mode |

## Verification
A change flag that was cleared by mistake, or that missed a set, shows on the very next read as a zero in bits 1, 3 or 5 after an input edge. A sequence counter that is off by one moves the fall of bit 6 or bit 8 by a cycle relative to the write. The bench checks that fall at an exact clock offset. A wrong completion decision shows as a wrong bit 2 in the first cycle after the reset bit clears. A stray suspend or owner state shows in bit 7 or bit 13 on the clock after the triggering edge.

// File: rtl/port_sc_pkg.sv
package port_sc_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned TEST_W    = 4;
  localparam int unsigned N_CHG     = 3;

  // field positions decoded by software
  localparam int unsigned B_ATT     = 0;
  localparam int unsigned B_ATT_CHG = 1;
  localparam int unsigned B_EN      = 2;
  localparam int unsigned B_EN_CHG  = 3;
  localparam int unsigned B_OVC     = 4;
  localparam int unsigned B_OVC_CHG = 5;
  localparam int unsigned B_RES     = 6;
  localparam int unsigned B_SUSP    = 7;
  localparam int unsigned B_RST     = 8;
  localparam int unsigned B_LINE    = 10;
  localparam int unsigned B_OWN     = 13;
  localparam int unsigned B_TEST    = 16;
  localparam int unsigned B_WK_ATT  = 20;
  localparam int unsigned B_WK_DET  = 21;

  localparam logic [REG_W-1:0] RST_VAL   = 32'h0000_2000;
  localparam logic [REG_W-1:0] PWR_MASK  = 32'h0030_01CF;

  // change-flag slots
  localparam int unsigned C_ATT = 0;
  localparam int unsigned C_EN  = 1;
  localparam int unsigned C_OVC = 2;
endpackage

// File: rtl/port_sticky_bit.sv
module port_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zero_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (zero_i) q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // hardware set beats the clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/port_seq_timer.sv
module port_seq_timer #(
  parameter int unsigned CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (flush_i)         cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/port_ctl_reg.sv
module port_ctl_reg
  import port_sc_pkg::*;
#(
  parameter int unsigned RESET_CYC  = 8,
  parameter int unsigned RESUME_CYC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              attach_i,
  input  logic              ovc_i,
  input  logic              jk_det_i,
  input  logic              hs_dev_i,
  input  logic              fault_i,
  input  logic              pwr_i,
  input  logic              cfg_i,
  input  logic [1:0]        line_i,
  output logic              port_chg_o,
  output logic              resume_o,
  output logic              rst_o,
  output logic              susp_o,
  output logic [TEST_W-1:0] test_mode_o
);
  logic att_q, en_q, ovc_q, res_q, susp_q, rst_q;
  logic wk_att_q, wk_det_q, own_q, cfg_q, chg_q;
  logic [TEST_W-1:0] test_q;

  logic wr_p;
  logic rst_start, rst_end_req, rst_busy, rst_done;
  logic res_end_req, res_busy, res_done;
  logic sw_res_set, hw_res_set;
  logic [N_CHG-1:0] chg_set, chg_clr, chg_zero, chg_flag;

  logic unused_wd;
  assign unused_wd = ^{wr_data_i[REG_W-1:22], wr_data_i[15:14], wr_data_i[12:9],
                       wr_data_i[B_ATT], wr_data_i[B_OVC]};

  assign wr_p        = wr_en_i & pwr_i;
  assign rst_start   = wr_p & ~rst_q & wr_data_i[B_RST];
  assign rst_end_req = wr_p & rst_q & ~rst_busy & ~wr_data_i[B_RST];
  assign res_end_req = wr_p & res_q & ~res_busy & ~wr_data_i[B_RES];
  assign sw_res_set  = wr_p & ~res_q & wr_data_i[B_RES];
  assign hw_res_set  = pwr_i & jk_det_i & susp_q & ~res_q;

  port_seq_timer #(.CYC(RESET_CYC)) u_rst_tmr (
    .clk_i, .rst_ni, .flush_i(~pwr_i), .start_i(rst_end_req),
    .busy_o(rst_busy), .done_o(rst_done)
  );

  port_seq_timer #(.CYC(RESUME_CYC)) u_res_tmr (
    .clk_i, .rst_ni, .flush_i(~pwr_i), .start_i(res_end_req),
    .busy_o(res_busy), .done_o(res_done)
  );

  // change flags: attach, enable (fault only), over-current
  assign chg_set[C_ATT]  = pwr_i & (attach_i != att_q);
  assign chg_set[C_EN]   = pwr_i & fault_i & en_q;
  assign chg_set[C_OVC]  = (ovc_i != ovc_q);
  assign chg_clr[C_ATT]  = wr_en_i & wr_data_i[B_ATT_CHG];
  assign chg_clr[C_EN]   = wr_en_i & wr_data_i[B_EN_CHG];
  assign chg_clr[C_OVC]  = wr_en_i & wr_data_i[B_OVC_CHG];
  assign chg_zero[C_ATT] = ~pwr_i;
  assign chg_zero[C_EN]  = ~pwr_i;
  assign chg_zero[C_OVC] = 1'b0;

  for (genvar g = 0; g < N_CHG; g++) begin : g_chg
    port_sticky_bit u_bit (
      .clk_i, .rst_ni, .zero_i(chg_zero[g]), .set_i(chg_set[g]),
      .clr_i(chg_clr[g]), .q_o(chg_flag[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovc_q  <= 1'b0;
      cfg_q  <= 1'b0;
      own_q  <= RST_VAL[B_OWN];
      test_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      ovc_q <= ovc_i;
      cfg_q <= cfg_i;
      chg_q <= hw_res_set & ~sw_res_set;
      if (!cfg_i)                own_q <= 1'b1;
      else if (!cfg_q)           own_q <= 1'b0;
      else if (wr_en_i)          own_q <= wr_data_i[B_OWN];
      if (wr_en_i) test_q <= wr_data_i[B_TEST +: TEST_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      att_q    <= 1'b0;
      en_q     <= 1'b0;
      res_q    <= 1'b0;
      susp_q   <= 1'b0;
      rst_q    <= 1'b0;
      wk_att_q <= 1'b0;
      wk_det_q <= 1'b0;
    end else if (!pwr_i) begin
      att_q    <= 1'b0;
      en_q     <= 1'b0;
      res_q    <= 1'b0;
      susp_q   <= 1'b0;
      rst_q    <= 1'b0;
      wk_att_q <= 1'b0;
      wk_det_q <= 1'b0;
    end else begin
      att_q <= attach_i;
      if (wr_en_i) begin
        wk_att_q <= wr_data_i[B_WK_ATT];
        wk_det_q <= wr_data_i[B_WK_DET];
      end
      if (rst_done)
        en_q <= hs_dev_i & att_q & attach_i;
      else if (fault_i | (att_q & ~attach_i) | (wr_en_i & ~wr_data_i[B_EN]) | rst_start)
        en_q <= 1'b0;
      if (rst_start)     rst_q <= 1'b1;
      else if (rst_done) rst_q <= 1'b0;
      if (sw_res_set | hw_res_set) res_q <= 1'b1;
      else if (res_done)           res_q <= 1'b0;
      if (rst_start | res_done)        susp_q <= 1'b0;
      else if (wr_p & wr_data_i[B_SUSP]) susp_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o                    = '0;
    rd_data_o[B_ATT]             = att_q;
    rd_data_o[B_ATT_CHG]         = chg_flag[C_ATT];
    rd_data_o[B_EN]              = en_q;
    rd_data_o[B_EN_CHG]          = chg_flag[C_EN];
    rd_data_o[B_OVC]             = ovc_q;
    rd_data_o[B_OVC_CHG]         = chg_flag[C_OVC];
    rd_data_o[B_RES]             = res_q;
    rd_data_o[B_SUSP]            = susp_q;
    rd_data_o[B_RST]             = rst_q;
    rd_data_o[B_LINE +: 2]       = (att_q & ~en_q) ? line_i : 2'b00;
    rd_data_o[B_OWN]             = own_q;
    rd_data_o[B_TEST +: TEST_W]  = test_q;
    rd_data_o[B_WK_ATT]          = wk_att_q;
    rd_data_o[B_WK_DET]          = wk_det_q;
  end

  assign port_chg_o  = chg_q;
  assign resume_o    = res_q;
  assign rst_o       = rst_q;
  assign susp_o      = susp_q;
  assign test_mode_o = test_q;
endmodule

module port_ctl_reg_chk
  import port_sc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwr_i,
  input logic             cfg_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             port_chg_o,
  input logic             resume_o,
  input logic             rst_o,
  input logic             susp_o
);
  // R2
  att_chg_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pwr_i) && (rd_data_o[B_ATT] != $past(rd_data_o[B_ATT]))) |-> rd_data_o[B_ATT_CHG]);
  // R9
  en_only_on_reset_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[B_EN]) |-> ($past(rst_o) && !rst_o));
  // R6
  chg_pulse_with_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_chg_o |-> (resume_o && !$past(resume_o)));
  // R7
  resume_end_clears_susp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(resume_o) |-> !susp_o);
  // R8
  susp_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(susp_o) |-> ($rose(rst_o) || $fell(resume_o) || !$past(pwr_i)));
  // R11
  owner_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_i) |-> rd_data_o[B_OWN]);
  // R13
  unpowered_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pwr_i) |-> ((rd_data_o & PWR_MASK) == '0));
endmodule

bind port_ctl_reg port_ctl_reg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_i(pwr_i), .cfg_i(cfg_i),
  .rd_data_o(rd_data_o), .port_chg_o(port_chg_o), .resume_o(resume_o),
  .rst_o(rst_o), .susp_o(susp_o)
);

// File: tb/port_ctl_reg_test.sv
module port_ctl_reg_test;
  localparam int unsigned RST_N = 4;
  localparam int unsigned RES_N = 3;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        attach_i = 0, ovc_i = 0, jk_det_i = 0, hs_dev_i = 0, fault_i = 0;
  logic        pwr_i = 0, cfg_i = 0;
  logic [1:0]  line_i = 2'b00;
  logic        port_chg_o, resume_o, rst_o, susp_o;
  logic [3:0]  test_mode_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  port_ctl_reg #(.RESET_CYC(RST_N), .RESUME_CYC(RES_N)) uut (.*);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic reset_tail(input logic hs);
    hs_dev_i = hs;
    wr(32'h0);
    chk("R9 rst held", 32'(rd_data_o[8]), 32'd1);
    for (int i = 0; i < int'(RST_N) - 1; i++) begin
      tick();
      chk("R9 rst held", 32'(rd_data_o[8]), 32'd1);
    end
    tick();
    chk("R9 rst end", 32'(rd_data_o[8]), 32'd0);
    chk("R9 en result", 32'(rd_data_o[2]), 32'(hs));
  endtask

  task automatic do_reset(input logic hs);
    wr(32'h100);
    chk("R9 rst start", {30'd0, rst_o, rd_data_o[8]}, 32'd3);
    reset_tail(hs);
  endtask

  task automatic resume_tail(input logic [31:0] d);
    wr(d);
    for (int i = 0; i < int'(RES_N) - 1; i++) begin
      chk("R7 res held", {30'd0, rd_data_o[7:6]}, 32'd3);
      tick();
    end
    chk("R7 res held", {30'd0, rd_data_o[7:6]}, 32'd3);
    tick();
    chk("R7 res end", {30'd0, rd_data_o[7:6]}, 32'd0);
  endtask

  initial begin
    logic [31:0] prev;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 reset value", rd_data_o, 32'h0000_2000);

    // unpowered
    attach_i = 1; tick();
    chk("R13 attach gated", 32'(rd_data_o[0]), 32'd0);
    wr(32'h0030_0000);
    chk("R13 wake gated", 32'(rd_data_o[21:20]), 32'd0);

    pwr_i = 1; tick();
    chk("R2 attach seen", rd_data_o, 32'h0000_2003);

    // owner
    cfg_i = 1; tick();
    chk("R11 cfg rise", rd_data_o, 32'h0000_0003);
    wr(32'h2000);
    chk("R11 sw write 1", rd_data_o, 32'h0000_2003);
    wr(32'h0);
    chk("R11 sw write 0", rd_data_o, 32'h0000_0003);
    cfg_i = 0; tick();
    chk("R11 cfg low", rd_data_o, 32'h0000_2003);
    cfg_i = 1; tick();
    chk("R11 cfg rise again", rd_data_o, 32'h0000_0003);

    // attach change flag
    wr(32'h2);
    chk("R2 w1c", rd_data_o, 32'h0000_0001);
    attach_i = 0; wr(32'h2);
    chk("R2 hw set wins", rd_data_o, 32'h0000_0002);
    attach_i = 1; tick();
    chk("R2 set while set", rd_data_o, 32'h0000_0003);

    prev = rd_data_o;
    wr(32'hFFC0_D611);
    chk("R1 reserved and ro ignored", rd_data_o, prev);

    // line status sweep
    for (int v = 0; v < 4; v++) begin
      line_i = 2'(v); tick();
      chk("R10 line shown", 32'(rd_data_o[11:10]), 32'(v));
    end
    attach_i = 0; tick();
    chk("R10 line hidden detached", 32'(rd_data_o[11:10]), 32'd0);
    attach_i = 1; tick();
    wr(32'h2);
    line_i = 2'b10;

    wr(32'h4);
    chk("R3 sw set ignored", 32'(rd_data_o[2]), 32'd0);

    do_reset(1'b1);
    chk("R10 line hidden enabled", 32'(rd_data_o[11:10]), 32'd0);

    // suspend and hardware resume
    wr(32'h84);
    chk("R8 susp set", {30'd0, susp_o, rd_data_o[7]}, 32'd3);
    wr(32'h04);
    chk("R8 write 0 ignored", 32'(rd_data_o[7]), 32'd1);
    jk_det_i = 1; tick(); jk_det_i = 0;
    chk("R6 hw resume", {30'd0, port_chg_o, rd_data_o[6]}, 32'd3);
    tick();
    chk("R6 pulse one cycle", 32'(port_chg_o), 32'd0);
    resume_tail(32'h04);

    // software resume
    wr(32'h84);
    wr(32'hC4);
    chk("R6 sw resume no pulse", {30'd0, port_chg_o, resume_o}, 32'd1);
    tick();
    chk("R6 sw resume no pulse later", 32'(port_chg_o), 32'd0);
    resume_tail(32'h84);

    // reset clears suspend, non-high-speed result
    wr(32'h84);
    wr(32'h180);
    chk("R8 reset clears susp", {29'd0, rd_data_o[8:7], rd_data_o[2]}, 32'b100);
    reset_tail(1'b0);

    do_reset(1'b1);
    wr(32'h0);
    chk("R3 sw zero clears", 32'(rd_data_o[3:2]), 32'd0);

    do_reset(1'b1);
    fault_i = 1; tick(); fault_i = 0;
    chk("R4 fault", 32'(rd_data_o[3:2]), 32'b10);
    wr(32'h8);
    chk("R4 w1c", 32'(rd_data_o[3]), 32'd0);
    fault_i = 1; tick(); fault_i = 0;
    chk("R4 fault while disabled", 32'(rd_data_o[3]), 32'd0);

    do_reset(1'b1);
    attach_i = 0; tick();
    chk("R3 detach", 32'(rd_data_o[3:0]), 32'b0010);
    attach_i = 1; tick();
    wr(32'h2);

    // over-current
    ovc_i = 1; tick();
    chk("R5 ovc rise", 32'(rd_data_o[5:4]), 32'b11);
    wr(32'h20);
    chk("R5 w1c", 32'(rd_data_o[5:4]), 32'b01);
    ovc_i = 0; tick();
    chk("R5 ovc fall", 32'(rd_data_o[5:4]), 32'b10);
    wr(32'h20);
    chk("R5 cleared", 32'(rd_data_o[5:4]), 32'b00);

    // test mode and wake sweep
    for (int m = 0; m < 16; m++) begin
      logic [3:0] mv;
      mv = 4'(m);
      wr({10'd0, mv[1:0], mv, 16'd0});
      chk("R12 field", 32'(rd_data_o[21:16]), {26'd0, mv[1:0], mv});
      chk("R12 output", 32'(test_mode_o), 32'(mv));
    end

    // power drop
    do_reset(1'b1);
    wr(32'h0030_0084);
    pwr_i = 0; tick();
    chk("R13 fields zero", rd_data_o & 32'h0030_0DCF, 32'd0);
    chk("R13 outputs", {29'd0, rst_o, susp_o, resume_o}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule